// File: doc/BRIEF.md
# Bus Hold and Halt Sequencer

This block decides who owns the bus and whether a small 8-bit processor is running, halted or parked for an external bus master. The timing unit advances one T-state per rising clock edge. The machine-cycle sequencer supplies three one-state markers:

- the state just ahead of T3;
- the state just ahead of T5;
- the state two ahead of each opcode-fetch T1.

The sequencer uses these markers to open short windows in which the external hold request and the interrupt lines are looked at. Outside those windows the request inputs have no effect while the processor runs.

While the processor is halted or in hold, both the hold request and the interrupt lines are captured on every state. Once an interrupt has been accepted, all interrupt sampling stops until the acknowledge input clears it. A stalled request therefore cannot be overtaken by a later one, even by the non-maskable TRAP line. When the processor is halted and a hold request is captured in the same state as an interrupt, the hold request is served first. The interrupt is remembered and taken as soon as hold ends.

Top module: `bus_hold_halt_seq`

## Requirements
- R1: A synchronous active-high reset sets `state_cls` to run (2'b00), drives `hlda` low and clears `int_valid`.
- R2: In run, `hold_req` is ignored except on an edge where `mk_pre_t3` or `mk_pre_t5` is high; without such a capture the block never enters hold.
- R3: In run, if `hold_req` is captured high on a marker edge k, the block stays in run at edge k+1 and enters hold (2'b10) at edge k+2.
- R4: In run, with no hold pending, `halt_ins` high at an edge moves the block to halt (2'b01) at that edge.
- R5: In halt and hold, `hold_req` is captured at every edge. If the captured value is high while halted, the block enters hold at the next edge.
- R6: In halt, a hold request captured in the same state as an interrupt still moves the block to hold; the interrupt is latched but not taken.
- R7: In hold, if the captured `hold_req` is low, the block leaves hold at the next edge. It goes back to halt if hold was entered from halt and no interrupt is latched; otherwise it goes to run.
- R8: Interrupt lines are sampled at every edge in halt or hold. In run they are sampled only on an edge where `mk_pre_fetch` is high.
- R9: While `int_valid` is high and `int_ack` is low, `int_valid` and `int_id` hold their values whatever `trap_req` and `irq_req` do.
- R10: The accepted identifier is 0 for TRAP and i+1 for `irq_req[i]`. TRAP outranks every line, and a lower line index outranks a higher one.
- R11: In halt with an interrupt latched and no captured hold request, the block moves to run at the next edge.
- R12: `hlda` is high exactly in the cycles where `state_cls` is hold.
- R13: `int_ack` high at an edge clears `int_valid` and blocks any capture at that same edge; sampling resumes from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hold_req | input | 1 | External bus hold request |
| trap_req | input | 1 | Non-maskable trap request |
| irq_req | input | N_IRQ | Unmasked, enabled interrupt request lines |
| halt_ins | input | 1 | Halt instruction decoded, processor enters halt |
| mk_pre_t3 | input | 1 | Current state is the last one before T3 |
| mk_pre_t5 | input | 1 | Current state is the last one before T5 |
| mk_pre_fetch | input | 1 | Current state is next-to-last before an opcode-fetch T1 |
| int_ack | input | 1 | Accepted interrupt serviced; clear the latch |
| hlda | output | 1 | Bus hold acknowledge |
| state_cls | output | 2 | State class: 00 run, 01 halt, 10 hold |
| int_valid | output | 1 | An interrupt is latched |
| int_id | output | ID_W | Identifier of the latched interrupt |

## Verification
Hold requests are applied in run both off-marker and on each of the two markers. This shows whether capture is truly limited to the marker edges and whether the two-edge entry delay is right. Hold and TRAP are raised together in halt, which shows that hold wins while the interrupt is still kept. The halt-hold-halt and halt-hold-run round trips show whether the block remembers where hold was entered from. Mixed-line interrupt patterns, late TRAPs and same-edge acknowledges test the priority order, the freeze after acceptance and the clear. A seeded random run then compares every output against a bench model on each cycle.

// File: rtl/hhs_pkg.sv
package hhs_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'b00,
      ST_HALT = 2'b01,
      ST_HOLD = 2'b10
   } seq_state_e;
endpackage

// File: rtl/hhs_hold_sampler.sv
// Captures the external hold request: every state in halt/hold, and only on
// marker states while running, with a one-state confirmation stage.
module hhs_hold_sampler (
   input  logic clk,
   input  logic rst,
   input  logic in_run,
   input  logic hold_req,
   input  logic mk_t3,
   input  logic mk_t5,
   output logic hold_lat,
   output logic hold_arm
);
   logic run_cap;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_lat <= 1'b0;
         run_cap  <= 1'b0;
         hold_arm <= 1'b0;
      end else begin
         hold_lat <= hold_req;
         run_cap  <= in_run & (mk_t3 | mk_t5) & hold_req;
         hold_arm <= in_run & run_cap;
      end
   end
endmodule

// File: rtl/hhs_int_latch.sv
// Priority-encodes the request lines and freezes the first accepted one.
module hhs_int_latch #(
   parameter int N_IRQ       = 4,
   parameter bit LOW_FIRST   = 1'b1,
   localparam int ID_W       = $clog2(N_IRQ + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sample_win,
   input  logic             trap_req,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic             ack,
   output logic             valid,
   output logic [ID_W-1:0]  id
);
   logic [ID_W-1:0] enc;
   logic            any_req;

   assign any_req = trap_req | (|irq_req);

   generate
      if (LOW_FIRST) begin : g_low_first
         always_comb begin
            enc = '0;
            for (int i = N_IRQ - 1; i >= 0; i--) begin
               if (irq_req[i]) enc = ID_W'(i + 1);
            end
            if (trap_req) enc = '0;
         end
      end else begin : g_high_first
         always_comb begin
            enc = '0;
            for (int i = 0; i < N_IRQ; i++) begin
               if (irq_req[i]) enc = ID_W'(i + 1);
            end
            if (trap_req) enc = '0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         id    <= '0;
      end else if (ack) begin
         valid <= 1'b0;
      end else if (!valid && sample_win && any_req) begin
         valid <= 1'b1;
         id    <= enc;
      end
   end
endmodule

// File: rtl/bus_hold_halt_seq.sv
module bus_hold_halt_seq #(
   parameter int N_IRQ     = 4,
   parameter bit LOW_FIRST = 1'b1,
   localparam int ID_W     = $clog2(N_IRQ + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hold_req,
   input  logic             trap_req,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic             halt_ins,
   input  logic             mk_pre_t3,
   input  logic             mk_pre_t5,
   input  logic             mk_pre_fetch,
   input  logic             int_ack,
   output logic             hlda,
   output logic [1:0]       state_cls,
   output logic             int_valid,
   output logic [ID_W-1:0]  int_id
);
   import hhs_pkg::*;

   generate
      if (N_IRQ < 1 || N_IRQ > 30) begin : g_bad_n_irq
         $error("bus_hold_halt_seq: N_IRQ must be 1..30");
      end
   endgenerate

   seq_state_e st_q, st_d;
   logic       from_halt_q;
   logic       hold_lat, hold_arm;
   logic       in_run, sample_win;

   assign in_run     = (st_q == ST_RUN);
   assign sample_win = !in_run || mk_pre_fetch;

   hhs_hold_sampler u_hold (
      .clk      (clk),
      .rst      (rst),
      .in_run   (in_run),
      .hold_req (hold_req),
      .mk_t3    (mk_pre_t3),
      .mk_t5    (mk_pre_t5),
      .hold_lat (hold_lat),
      .hold_arm (hold_arm)
   );

   hhs_int_latch #(.N_IRQ(N_IRQ), .LOW_FIRST(LOW_FIRST)) u_int (
      .clk        (clk),
      .rst        (rst),
      .sample_win (sample_win),
      .trap_req   (trap_req),
      .irq_req    (irq_req),
      .ack        (int_ack),
      .valid      (int_valid),
      .id         (int_id)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN: begin
            if (hold_arm)      st_d = ST_HOLD;
            else if (halt_ins) st_d = ST_HALT;
         end
         ST_HALT: begin
            if (hold_lat)       st_d = ST_HOLD;
            else if (int_valid) st_d = ST_RUN;
         end
         ST_HOLD: begin
            if (!hold_lat) st_d = (from_halt_q && !int_valid) ? ST_HALT : ST_RUN;
         end
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q        <= ST_RUN;
         from_halt_q <= 1'b0;
         hlda        <= 1'b0;
      end else begin
         st_q <= st_d;
         hlda <= (st_d == ST_HOLD);
         if (st_q != ST_HOLD && st_d == ST_HOLD) from_halt_q <= (st_q == ST_HALT);
      end
   end

   assign state_cls = st_q;
endmodule

// File: rtl/hhs_checker.sv
module hhs_checker #(
   parameter int ID_W = 3
) (
   input logic            clk,
   input logic            rst,
   input logic            halt_ins,
   input logic            int_ack,
   input logic            hlda,
   input logic [1:0]      state_cls,
   input logic            int_valid,
   input logic [ID_W-1:0] int_id,
   input logic            hold_lat,
   input logic            hold_arm
);
   a_r1_reset_run: assert property (@(posedge clk) rst |=> (state_cls == 2'b00 && !hlda && !int_valid));

   a_r12_hlda_tracks_hold: assert property (@(posedge clk) disable iff (rst)
      hlda == (state_cls == 2'b10));

   a_r2_no_hold_unarmed: assert property (@(posedge clk) disable iff (rst)
      (state_cls == 2'b00 && !hold_arm) |=> state_cls != 2'b10);

   a_r4_halt_entry: assert property (@(posedge clk) disable iff (rst)
      (state_cls == 2'b00 && !hold_arm && halt_ins) |=> state_cls == 2'b01);

   a_r5_halt_to_hold: assert property (@(posedge clk) disable iff (rst)
      (state_cls == 2'b01 && hold_lat) |=> state_cls == 2'b10);

   a_r7_hold_exit: assert property (@(posedge clk) disable iff (rst)
      (state_cls == 2'b10 && !hold_lat) |=> state_cls != 2'b10);

   a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
      (int_valid && !int_ack) |=> (int_valid && $stable(int_id)));

   a_r13_ack_clears: assert property (@(posedge clk) disable iff (rst)
      int_ack |=> !int_valid);

   a_r11_halt_wake: assert property (@(posedge clk) disable iff (rst)
      (state_cls == 2'b01 && int_valid && !hold_lat) |=> state_cls == 2'b00);
endmodule

bind bus_hold_halt_seq hhs_checker #(.ID_W(ID_W)) u_hhs_checker (
   .clk       (clk),
   .rst       (rst),
   .halt_ins  (halt_ins),
   .int_ack   (int_ack),
   .hlda      (hlda),
   .state_cls (state_cls),
   .int_valid (int_valid),
   .int_id    (int_id),
   .hold_lat  (hold_lat),
   .hold_arm  (hold_arm)
);

// File: tb/bus_hold_halt_seq_bench.sv
`timescale 1ns/1ps
module bus_hold_halt_seq_bench;
   localparam int N_IRQ = 4;
   localparam int ID_W  = $clog2(N_IRQ + 1);

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             hold_req = 1'b0, trap_req = 1'b0, halt_ins = 1'b0;
   logic [N_IRQ-1:0] irq_req = '0;
   logic             mk_pre_t3 = 1'b0, mk_pre_t5 = 1'b0, mk_pre_fetch = 1'b0, int_ack = 1'b0;
   logic             hlda, int_valid;
   logic [1:0]       state_cls;
   logic [ID_W-1:0]  int_id;

   int n_chk = 0;
   int n_fail = 0;

   // bench model state
   logic [1:0]      m_st = 2'b00;
   logic            m_hl = 0, m_cap = 0, m_arm = 0, m_frm = 0, m_iv = 0;
   logic [ID_W-1:0] m_id = '0;

   always #2.5 clk = ~clk;

   bus_hold_halt_seq #(.N_IRQ(N_IRQ)) u_bus_hold_halt_seq (
      .clk(clk), .rst(rst), .hold_req(hold_req), .trap_req(trap_req),
      .irq_req(irq_req), .halt_ins(halt_ins), .mk_pre_t3(mk_pre_t3),
      .mk_pre_t5(mk_pre_t5), .mk_pre_fetch(mk_pre_fetch), .int_ack(int_ack),
      .hlda(hlda), .state_cls(state_cls), .int_valid(int_valid), .int_id(int_id)
   );

   function automatic logic [ID_W-1:0] exp_id(input logic t, input logic [N_IRQ-1:0] q);
      logic [ID_W-1:0] r = '0;
      for (int i = N_IRQ - 1; i >= 0; i--) if (q[i]) r = ID_W'(i + 1);
      if (t) r = '0;
      return r;
   endfunction

   function automatic logic [1:0] exp_next(input logic [1:0] s);
      case (s)
         2'b00:   return m_arm ? 2'b10 : (halt_ins ? 2'b01 : 2'b00);
         2'b01:   return m_hl ? 2'b10 : (m_iv ? 2'b00 : 2'b01);
         default: return !m_hl ? ((m_frm && !m_iv) ? 2'b01 : 2'b00) : 2'b10;
      endcase
   endfunction

   task automatic model_step();
      logic [1:0] nst;
      if (rst) begin
         m_st = 2'b00; m_hl = 0; m_cap = 0; m_arm = 0; m_frm = 0; m_iv = 0; m_id = '0;
      end else begin
         nst = exp_next(m_st);
         if (m_st != 2'b10 && nst == 2'b10) m_frm = (m_st == 2'b01);
         if (int_ack) m_iv = 0;
         else if (!m_iv && (m_st != 2'b00 || mk_pre_fetch) && (trap_req || |irq_req)) begin
            m_iv = 1; m_id = exp_id(trap_req, irq_req);
         end
         m_arm = (m_st == 2'b00) && m_cap;
         m_cap = (m_st == 2'b00) && (mk_pre_t3 || mk_pre_t5) && hold_req;
         m_hl  = hold_req;
         m_st  = nst;
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_model();
      chk("R12 random model hlda", {31'd0, hlda}, {31'd0, m_st == 2'b10});
      chk("R7 random model state", {30'd0, state_cls}, {30'd0, m_st});
      chk("R8 random model valid", {31'd0, int_valid}, {31'd0, m_iv});
      if (m_iv) chk("R10 random model id", {{(32-ID_W){1'b0}}, int_id}, {{(32-ID_W){1'b0}}, m_id});
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(5ns * 150000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      int unsigned seed = 32'd1234;
      void'($urandom(seed));
      @(negedge clk);
      tick(); tick();
      // R1
      chk("R1 state", {30'd0, state_cls}, 0);
      chk("R1 hlda", {31'd0, hlda}, 0);
      chk("R1 valid", {31'd0, int_valid}, 0);
      rst = 0;
      // R2: hold high without markers
      hold_req = 1;
      repeat (4) tick();
      chk("R2 no capture off-marker", {30'd0, state_cls}, 0);
      chk("R2 hlda low", {31'd0, hlda}, 0);
      // R3: capture on pre-T3 marker
      mk_pre_t3 = 1; tick(); mk_pre_t3 = 0;
      tick();
      chk("R3 still run at k+1", {30'd0, state_cls}, 0);
      tick();
      chk("R3 hold at k+2", {30'd0, state_cls}, 2);
      chk("R12 hlda in hold", {31'd0, hlda}, 1);
      hold_req = 0; tick();
      chk("R7 hold kept one state", {30'd0, state_cls}, 2);
      tick();
      chk("R7 back to run", {30'd0, state_cls}, 0);
      chk("R12 hlda dropped", {31'd0, hlda}, 0);
      // R4
      halt_ins = 1; tick(); halt_ins = 0;
      chk("R4 halt entered", {30'd0, state_cls}, 1);
      // R5/R6: hold and trap together in halt
      hold_req = 1; trap_req = 1; tick(); trap_req = 0;
      chk("R6 stays halt, int latched", {30'd0, state_cls}, 1);
      chk("R6 trap latched", {31'd0, int_valid}, 1);
      irq_req = 4'b0001; tick(); irq_req = '0;
      chk("R5 hold from halt", {30'd0, state_cls}, 2);
      chk("R9 id frozen", {{(32-ID_W){1'b0}}, int_id}, 0);
      hold_req = 0; tick(); tick();
      chk("R11 hold exit to run with int", {30'd0, state_cls}, 0);
      // R13: ack with simultaneous request
      int_ack = 1; irq_req = 4'b0100; mk_pre_fetch = 1; tick(); int_ack = 0; mk_pre_fetch = 0;
      chk("R13 cleared by ack", {31'd0, int_valid}, 0);
      // R8: no fetch marker, no sampling in run
      tick();
      chk("R8 run ignores irq off-marker", {31'd0, int_valid}, 0);
      irq_req = 4'b0110; mk_pre_fetch = 1; tick(); mk_pre_fetch = 0; irq_req = '0;
      chk("R8 sampled on fetch marker", {31'd0, int_valid}, 1);
      chk("R10 lowest index wins", {{(32-ID_W){1'b0}}, int_id}, 2);
      trap_req = 1; mk_pre_fetch = 1; tick(); trap_req = 0; mk_pre_fetch = 0;
      chk("R9 later trap ignored", {{(32-ID_W){1'b0}}, int_id}, 2);
      int_ack = 1; tick(); int_ack = 0;
      // R7 return to halt
      halt_ins = 1; tick(); halt_ins = 0;
      hold_req = 1; tick(); tick();
      chk("R5 hold entered", {30'd0, state_cls}, 2);
      hold_req = 0; tick(); tick();
      chk("R7 back to halt", {30'd0, state_cls}, 1);
      irq_req = 4'b1000; tick(); irq_req = '0;
      chk("R10 id of line 3", {{(32-ID_W){1'b0}}, int_id}, 4);
      tick();
      chk("R11 halt wakes to run", {30'd0, state_cls}, 0);
      int_ack = 1; tick(); int_ack = 0;
      // pre-T5 marker
      hold_req = 1; mk_pre_t5 = 1; tick(); mk_pre_t5 = 0; tick(); tick();
      chk("R3 hold via pre-T5 marker", {30'd0, state_cls}, 2);
      hold_req = 0; tick(); tick();
      chk_model();
      // random phase
      for (int c = 0; c < 4000; c++) begin
         hold_req     = ($urandom % 4) != 0;
         trap_req     = ($urandom % 16) == 0;
         irq_req      = (($urandom % 6) == 0) ? N_IRQ'($urandom) : '0;
         halt_ins     = ($urandom % 12) == 0;
         mk_pre_t3    = ($urandom % 5) == 0;
         mk_pre_t5    = ($urandom % 9) == 0;
         mk_pre_fetch = ($urandom % 4) == 0;
         int_ack      = ($urandom % 7) == 0;
         rst          = ($urandom % 1000) == 0;
         tick();
         chk_model();
      end
      finish_run();
   end
endmodule